// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block turns the system clock into a steady stream of interrupt requests for a small expansion bus. Software loads a 16-bit divisor and picks one of seven priority levels. Once the timer is enabled, it raises a request every divisor clock cycles. The request is driven as an active-low, 3-bit encoded level together with a pending flag.

A request stays raised until software services it. Software clears it in one of two ways: by writing the status register, or by running an acknowledge cycle at the matching level. If another period ends while a request is still raised, an overrun flag records the missed service.

By default the acknowledge is autovectored. A control bit can select vectored mode instead. In that mode the block returns a programmable 8-bit vector during the acknowledge.

Top module: `tick_irq_timer`

Register map (byte-wide, `bus_addr`):

| Address | Contents |
|---|---|
| 0 | divisor bits 7:0 |
| 1 | divisor bits 15:8 |
| 2 | control: bit 0 enable, bits 3:1 level, bit 4 vectored mode |
| 3 | status: bit 0 pending, bit 1 overrun; a write of 1 to a bit clears it |
| 4 | vector |

Unused bits read as 0.

## Requirements
- R1: After reset, `irq_n` is 3'b111, `irq_pending` is 0, `ack_auto` and `vec_valid` are 0, and registers 0 to 4 all read 0.
- R2: With a divisor D other than 0, the first request appears D+1 cycles after the write edge that sets enable. This is one start cycle followed by D counts. Later requests follow every D cycles.
- R3: While the level is 0, no request is raised: `irq_pending` stays 0 and `irq_n` stays 3'b111.
- R4: While a request is pending, `irq_n` equals the bitwise inverse of the programmed level.
- R5: A pending request is held until it is cleared. It is cleared by writing 1 to status bit 0, or by `iack` with `iack_level` equal to the level. An acknowledge at any other level leaves it pending.
- R6: When a period ends while the request is still pending and not being cleared, status bit 1 (overrun) is set. Overrun is cleared only by writing 1 to status bit 1.
- R7: A new divisor written during a period does not alter that period. It takes effect from the next reload.
- R8: A divisor of 0 produces no requests, even when enable is set.
- R9: Clearing enable stops the counter, drops any pending request on the next edge, and leaves overrun unchanged.
- R10: During a matching acknowledge, `ack_auto` is 1 when control bit 4 is 0. When control bit 4 is 1, `vec_valid` is 1 and `vec_out` carries register 4 instead.
- R11: If a period ends in the same cycle as a clear, the new request wins. Pending stays 1 and overrun is not set.
- R12: Divisor, control (5 bits) and vector registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| iack | input | 1 | Interrupt acknowledge cycle |
| iack_level | input | 3 | Level being acknowledged |
| irq_n | output | 3 | Active-low encoded request level |
| irq_pending | output | 1 | Request raised |
| ack_auto | output | 1 | Matching acknowledge in autovectored mode |
| vec_valid | output | 1 | Matching acknowledge in vectored mode |
| vec_out | output | 8 | Vector during a vectored acknowledge, else 0 |

## Verification
The end of a period and a clear of the pending request can land on the same clock edge. The bench provokes this by programming a divisor of 1 and acknowledging the first request as soon as it is seen, so the acknowledge edge is also a reload edge. The outcome is judged through the status register: pending must still read 1 and overrun must read 0. The bench also sweeps divisors 1 to 16 plus one value that uses the upper byte, and predicts each request's cycle as D+1 and 2D+1 from the enable edge.

// File: rtl/tick_irq_pkg.sv
// Shared definitions for the periodic interrupt timer.
// Assumes a 3-bit encoded priority level, where level 0 means "no request".
package tick_irq_pkg;
    localparam int LVL_W = 3;

    typedef struct packed {
        logic               vmode;   // 1: vectored acknowledge
        logic [LVL_W-1:0]   level;   // requested priority, 0 = none
        logic               en;      // timer enable
    } ctrl_t;
endpackage

// File: rtl/tick_regs.sv
// Byte-wide register file: divisor bytes, control, status and optional vector.
// Assumes one access per cycle, with writes qualified by sel & wr and a combinational read.
// Address map: divisor bytes at 0..DIV_BYTES-1, then control, status and vector.
module tick_regs
    import tick_irq_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 3,
    parameter bit HAS_VEC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pending,
    input  logic              overrun,
    output logic [DIV_W-1:0]  divisor,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] vector,
    output logic              clr_pend,
    output logic              clr_ovr
);
    localparam int DIV_BYTES = DIV_W / DATA_W;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(DIV_BYTES);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(DIV_BYTES + 1);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(DIV_BYTES + 2);

    logic  we;
    ctrl_t ctrl_q;

    assign we       = sel && wr;
    assign ctrl     = ctrl_q;
    assign clr_pend = we && (addr == A_STAT) && wdata[0];
    assign clr_ovr  = we && (addr == A_STAT) && wdata[1];

    // One byte lane of the divisor per generate iteration.
    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
        // Capture a divisor byte on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                divisor[b*DATA_W +: DATA_W] <= '0;
            else if (we && addr == ADDR_W'(b))
                divisor[b*DATA_W +: DATA_W] <= wdata;
        end
    end

    // Capture the control fields; vectored mode sticks at 0 without a vector register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we && addr == A_CTRL) begin
            ctrl_q.en    <= wdata[0];
            ctrl_q.level <= wdata[LVL_W:1];
            ctrl_q.vmode <= HAS_VEC ? wdata[LVL_W+1] : 1'b0;
        end
    end

    if (HAS_VEC) begin : g_vec
        // Hold the vector returned during a vectored acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vector <= '0;
            else if (we && addr == A_VEC)
                vector <= wdata;
        end
    end else begin : g_novec
        assign vector = '0;
    end

    // Select read data for the addressed register.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < DIV_BYTES; b++)
            if (addr == ADDR_W'(b))
                rdata = divisor[b*DATA_W +: DATA_W];
        if (addr == A_CTRL) rdata = DATA_W'(ctrl_q);
        if (addr == A_STAT) rdata = DATA_W'({overrun, pending});
        if (addr == A_VEC)  rdata = vector;
    end
endmodule

// File: rtl/tick_div.sv
// Down-counting divider that emits a one-cycle tick once every `divisor` cycles.
// Assumes a start cycle after it is enabled. A divisor of 0 or a cleared
// enable halts it. The divisor is only sampled at a start or a reload.
module tick_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic             active_q;
    logic             run;

    assign run  = en && (divisor != '0);
    assign tick = run && active_q && (cnt_q == '0);

    // Start, reload or decrement the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (!run) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (!active_q || cnt_q == '0) begin
            active_q <= 1'b1;
            cnt_q    <= divisor - ONE;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assert_div0_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |-> !tick);
    assert_stopped_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick);
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || $past(divisor) == ONE));
endmodule

// File: rtl/tick_req.sv
// Request holder: sets pending on a tick at a nonzero level, flags overrun,
// clears pending on a status write or a matching acknowledge, and drives
// the active-low level code and the acknowledge responses.
// Assumes a new tick outranks a clear that falls in the same cycle.
module tick_req
    import tick_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LVL_W-1:0]  level,
    input  logic              vmode,
    input  logic [DATA_W-1:0] vector,
    input  logic              tick,
    input  logic              clr_pend,
    input  logic              clr_ovr,
    input  logic              iack,
    input  logic [LVL_W-1:0]  iack_level,
    output logic              pending,
    output logic              overrun,
    output logic [LVL_W-1:0]  irq_n,
    output logic              ack_auto,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_out
);
    logic fire;
    logic ack_hit;
    logic clear;

    assign fire      = tick && (level != '0);
    assign ack_hit   = iack && pending && (iack_level == level) && (level != '0);
    assign clear     = clr_pend || ack_hit;
    assign irq_n     = pending ? ~level : '1;
    assign ack_auto  = ack_hit && !vmode;
    assign vec_valid = ack_hit && vmode;
    assign vec_out   = vec_valid ? vector : '0;

    // Track the pending request; a fresh tick wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (!en)
            pending <= 1'b0;
        else if (fire)
            pending <= 1'b1;
        else if (clear)
            pending <= 1'b0;
    end

    // Record a tick that arrives while the previous request is still unserviced.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else
            overrun <= (overrun && !clr_ovr) || (en && fire && pending && !clear);
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pending && !clear) |=> pending);
    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fire && pending && !clear) |=> overrun);
    assert_level0_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && !pending) |=> !pending);
    assert_disable_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pending);
    assert_collide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fire && clear) |=> (pending && (overrun == $past(overrun && !clr_ovr))));
endmodule

// File: rtl/tick_irq_timer.sv
// Top level of the periodic interrupt timer: registers, divider and request holder.
// Assumes a single clock domain and a synchronous active-low reset.
module tick_irq_timer
    import tick_irq_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 3,
    parameter bit HAS_VEC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              iack,
    input  logic [LVL_W-1:0]  iack_level,
    output logic [LVL_W-1:0]  irq_n,
    output logic              irq_pending,
    output logic              ack_auto,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_out
);
    logic [DIV_W-1:0]  divisor;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] vector;
    logic              clr_pend;
    logic              clr_ovr;
    logic              tick;
    logic              overrun;

    tick_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HAS_VEC(HAS_VEC)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .pending(irq_pending), .overrun(overrun),
        .divisor(divisor), .ctrl(ctrl), .vector(vector),
        .clr_pend(clr_pend), .clr_ovr(clr_ovr)
    );

    tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .divisor(divisor), .tick(tick)
    );

    tick_req #(.DATA_W(DATA_W)) u_req (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .level(ctrl.level), .vmode(ctrl.vmode),
        .vector(vector), .tick(tick), .clr_pend(clr_pend), .clr_ovr(clr_ovr),
        .iack(iack), .iack_level(iack_level), .pending(irq_pending), .overrun(overrun),
        .irq_n(irq_n), .ack_auto(ack_auto), .vec_valid(vec_valid), .vec_out(vec_out)
    );
endmodule

// File: tb/tick_irq_timer_tb.sv
`timescale 1ns/1ps
module tick_irq_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd3;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       iack = 1'b0;
    logic [2:0] iack_level = 3'd0;
    logic [2:0] irq_n;
    logic       irq_pending, ack_auto, vec_valid;
    logic [7:0] vec_out;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    tick_irq_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .iack(iack), .iack_level(iack_level),
        .irq_n(irq_n), .irq_pending(irq_pending), .ack_auto(ack_auto),
        .vec_valid(vec_valid), .vec_out(vec_out)
    );

    always #2.5 clk = ~clk;

    // Cycle count and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 3'd3;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = 3'(a);
        #0.5;
        d = int'(bus_rdata);
        bus_addr = 3'd3;
    endtask

    task automatic wait_pend(input int start, output int delta);
        for (int g = 0; g < 70000 && !irq_pending; g++) @(negedge clk);
        delta = cyc - start;
    endtask

    task automatic ack(input int lvl);
        iack = 1'b1; iack_level = 3'(lvl);
        @(negedge clk);
        iack = 1'b0;
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic stop_all();
        wr(2, 0);
        wr(3, 3);
    endtask

    initial begin
        int e, d, v, lvl;
        idle_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq_n == 3'b111 && !irq_pending && !ack_auto && !vec_valid, "R1 outputs",
              int'({irq_n, irq_pending}), 14);
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            check(v == 0, "R1 register read", v, 0);
        end

        // R12 read-back without enable
        wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'h1E); wr(4, 8'h77);
        rd(0, v); check(v == 8'hA5, "R12 divisor low", v, 8'hA5);
        rd(1, v); check(v == 8'h3C, "R12 divisor high", v, 8'h3C);
        rd(2, v); check(v == 8'h1E, "R12 control", v, 8'h1E);
        rd(4, v); check(v == 8'h77, "R12 vector", v, 8'h77);
        wr(2, 0);

        // R2/R4/R5/R11 divisor sweep, plus one value using the high byte
        for (int i = 1; i <= 17; i++) begin
            int dv;
            dv = (i == 17) ? 300 : i;
            lvl = (dv % 7) + 1;
            wr(0, dv & 8'hFF); wr(1, dv >> 8);
            wr(2, 1 | (lvl << 1));
            e = cyc;
            wait_pend(e, d);
            check(d == dv + 1, "R2 first request delay", d, dv + 1);
            check(irq_n == 3'(~lvl), "R4 level code", int'(irq_n), int'(3'(~lvl)));
            ack(lvl);
            if (dv == 1) begin
                rd(3, v);
                check(v == 1, "R11 tick and clear same edge", v, 1);
            end else begin
                check(!irq_pending, "R5 acknowledge clears", int'(irq_pending), 0);
                wait_pend(e, d);
                check(d == 2 * dv + 1, "R2 second request delay", d, 2 * dv + 1);
            end
            stop_all();
        end

        // R5 wrong-level acknowledge ignored, status write clears
        wr(0, 50); wr(1, 0); wr(2, 1 | (3 << 1));
        e = cyc; wait_pend(e, d);
        ack(2);
        check(irq_pending, "R5 wrong level ignored", int'(irq_pending), 1);
        wr(3, 1);
        check(!irq_pending, "R5 status write clears", int'(irq_pending), 0);
        stop_all();

        // R6 overrun, then R9 keeps overrun while dropping pending
        wr(0, 4); wr(2, 1 | (5 << 1));
        e = cyc; wait_pend(e, d);
        idle_n(5);
        rd(3, v); check(v == 3, "R6 overrun set", v, 3);
        wr(2, 5 << 1);
        @(negedge clk);
        rd(3, v); check(v == 2, "R9 pending dropped overrun kept", v, 2);
        wr(3, 2);
        rd(3, v); check(v == 0, "R6 overrun cleared by write", v, 0);

        // R3 level zero raises nothing
        wr(0, 3); wr(2, 1);
        idle_n(20);
        check(!irq_pending && irq_n == 3'b111, "R3 level zero silent",
              int'({irq_n, irq_pending}), 14);
        stop_all();

        // R7 divisor change waits for the next reload
        wr(0, 10); wr(1, 0); wr(2, 1 | (2 << 1));
        e = cyc;
        wr(0, 4);
        wait_pend(e, d);
        check(d == 11, "R7 current period kept", d, 11);
        ack(2);
        wait_pend(e, d);
        check(d == 15, "R7 new period used", d, 15);
        stop_all();

        // R8 divisor zero produces nothing until a divisor is loaded
        wr(0, 0); wr(1, 0); wr(2, 1 | (1 << 1));
        idle_n(30);
        check(!irq_pending, "R8 divisor zero silent", int'(irq_pending), 0);
        wr(0, 5);
        e = cyc; wait_pend(e, d);
        check(d == 6, "R8 start after divisor load", d, 6);
        stop_all();

        // R9 disable drops a pending request and halts
        wr(0, 3); wr(2, 1 | (4 << 1));
        e = cyc; wait_pend(e, d);
        wr(2, 4 << 1);
        @(negedge clk);
        check(!irq_pending && irq_n == 3'b111, "R9 request dropped",
              int'({irq_n, irq_pending}), 14);
        idle_n(20);
        check(!irq_pending, "R9 stays stopped", int'(irq_pending), 0);
        stop_all();

        // R10 vectored then autovectored acknowledge
        wr(4, 8'h4A); wr(0, 3); wr(2, 1 | (6 << 1) | 16);
        e = cyc; wait_pend(e, d);
        iack = 1'b1; iack_level = 3'd6;
        #0.5;
        check(vec_valid && !ack_auto && vec_out == 8'h4A, "R10 vectored",
              int'(vec_out), 8'h4A);
        @(negedge clk); iack = 1'b0;
        wr(2, 1 | (6 << 1));
        e = cyc; wait_pend(e, d);
        iack = 1'b1; iack_level = 3'd6;
        #0.5;
        check(ack_auto && !vec_valid && vec_out == 8'h00, "R10 autovectored",
              int'({ack_auto, vec_valid}), 2);
        @(negedge clk); iack = 1'b0;
        stop_all();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule